// File: doc/BRIEF.md
# Physical Memory Protection Access Checker

This block decides whether one memory access may proceed under a set of protection entries. Each entry has a small configuration field (an address-matching mode plus read, write and execute permission bits), an address register and a lock flag that arrives already resolved. The access is described by its byte address, its size in bytes, the permissions it needs and whether it comes from machine mode. The checker turns every entry into an inclusive byte range, tests the first and last byte of the access against each range, and lets the lowest-numbered entry that touches the access decide the result.

The result is a grant flag and the permission mask in force for the access. An access that is only partly inside the deciding entry's range is refused. Machine-mode accesses are restricted only by locked entries. An access that no entry touches is allowed with full permissions in machine mode and refused in every other mode. The decision logic is combinational; an output register, selected by a parameter and present by default, adds one cycle of latency for timing.

Top module: `pmp_access_checker`

## Requirements
- R1: Configuration field layout per entry is bits [2:0] = permissions (bit 0 read, bit 1 write, bit 2 execute) and bits [4:3] = mode (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two). An entry in mode 0 never matches and never causes a partial match, whatever its address and permissions.
- R2: In mode 1, entry i covers byte addresses from (address register of entry i-1) times 4 up to (its own address register times 4) minus 1, computed modulo 2^(XLEN+2); entry 0 uses 0 as the lower bound.
- R3: In mode 2 an entry covers exactly four bytes starting at its address register times 4.
- R4: In mode 3, with t the number of trailing one bits of the address register, the entry covers 2^(t+3) bytes starting at (the register with its low t bits cleared) times 4.
- R5: In mode 3 an address register of all ones covers the whole address space.
- R6: Entries are examined from index 0 upward; the first entry that contains the first byte or the last byte of the access decides the result and higher entries are ignored.
- R7: If the deciding entry contains exactly one of the first and last byte, the access is refused and the output permission mask is 0.
- R8: If the deciding entry contains both bytes, the mask is 7 (read, write, execute) for a machine-mode access to an unlocked entry and the entry's own permission bits otherwise; grant is 1 exactly when every requested permission bit is set in that mask.
- R9: If no entry decides (including when every entry is off), a machine-mode access gets grant 1 and mask 7, and any other access gets grant 0 and mask 0.
- R10: The last byte is the address plus the size minus 1 (modulo 2^(XLEN+2)); a size of 0 means the last byte is the final byte of the page (PAGE_BYTES, default 4096) that holds the address.
- R11: With the output register enabled, grant and mask reflect the inputs sampled at the previous rising clock edge, and both are 0 while synchronous reset is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | XLEN+2 | Byte address of the access |
| acc_size | input | SIZE_W | Access size in bytes, 0 means to end of page |
| acc_perm | input | 3 | Requested permissions, bit 0 read, bit 1 write, bit 2 execute |
| acc_machine | input | 1 | 1 when the access is made in machine mode |
| cfg_flat | input | NUM_ENTRIES*5 | Per-entry configuration, entry i in bits [5i+4:5i] |
| addr_flat | input | NUM_ENTRIES*XLEN | Per-entry address register, entry i in bits [XLEN*i+XLEN-1:XLEN*i] |
| lock_flat | input | NUM_ENTRIES | Per-entry resolved lock flag |
| grant | output | 1 | Access allowed |
| allow_perm | output | 3 | Permission mask in force for the access |

## Verification
The bench aims at range edges: the first and last byte of top-of-range and four-byte regions, and accesses one byte across them, where an off-by-one decoder would grant a straddling access or refuse a fitting one. Power-of-two regions with varied trailing-one counts and the all-ones register catch a decoder that miscounts the size or fails to cover the full space. Overlapping entries check that the lowest index wins, and machine-mode accesses to locked and unlocked entries check the lock rule, where a wrong design would either block machine mode everywhere or never. Size-zero accesses near a region's end catch a design that takes the last byte as the address itself instead of the page end.

// File: rtl/pmpchk_pkg.sv
`timescale 1ns/1ps
package pmpchk_pkg;

    // Address-matching mode held in configuration bits [4:3].
    typedef enum logic [1:0] {
        AM_OFF   = 2'd0,
        AM_TOR   = 2'd1,
        AM_NA4   = 2'd2,
        AM_NAPOT = 2'd3
    } amode_e;

    // Permission bits, read in bit 0.
    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    localparam int CFG_W  = 5;
    localparam int PERM_W = 3;

    localparam perm_t PERM_ALL  = '{x: 1'b1, w: 1'b1, r: 1'b1};
    localparam perm_t PERM_NONE = '{x: 1'b0, w: 1'b0, r: 1'b0};

    function automatic amode_e cfg_mode(input logic [CFG_W-1:0] c);
        return amode_e'(c[4:3]);
    endfunction

    function automatic perm_t cfg_perm(input logic [CFG_W-1:0] c);
        return perm_t'(c[2:0]);
    endfunction

    // True when every bit asked for is present in the allowed set.
    function automatic logic perm_covers(input perm_t want, input perm_t have);
        return (want & ~have) == PERM_NONE;
    endfunction

endpackage

// File: rtl/pmp_range_decode.sv
`timescale 1ns/1ps
module pmp_range_decode
    import pmpchk_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  amode_e            mode_i,
    input  logic [XLEN-1:0]   addr_i,
    input  logic [XLEN-1:0]   prev_i,
    output logic              valid_o,
    output logic [XLEN+1:0]   start_o,
    output logic [XLEN+1:0]   end_o
);
    localparam int AW = XLEN + 2;

    logic [AW-1:0] this_sh;
    logic [AW-1:0] prev_sh;
    logic [AW-1:0] ones_ext;
    logic [AW-1:0] napot_mask;

    // Appending two ones gives t+2 trailing ones; xor with its increment
    // yields a mask of the low t+3 bits, which is the region size minus 1.
    always_comb begin
        this_sh    = {addr_i, 2'b00};
        prev_sh    = {prev_i, 2'b00};
        ones_ext   = {addr_i, 2'b11};
        napot_mask = ones_ext ^ (ones_ext + AW'(1));
    end

    always_comb begin
        valid_o = 1'b1;
        start_o = '0;
        end_o   = '0;
        unique case (mode_i)
            AM_TOR: begin
                start_o = prev_sh;
                end_o   = this_sh - AW'(1);
            end
            AM_NA4: begin
                start_o = this_sh;
                end_o   = this_sh | AW'(3);
            end
            AM_NAPOT: begin
                start_o = ones_ext & ~napot_mask;
                end_o   = ones_ext | napot_mask;
            end
            default: begin
                valid_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pmp_entry_hit.sv
`timescale 1ns/1ps
module pmp_entry_hit #(
    parameter int AW = 34
) (
    input  logic          valid_i,
    input  logic [AW-1:0] start_i,
    input  logic [AW-1:0] end_i,
    input  logic [AW-1:0] first_i,
    input  logic [AW-1:0] last_i,
    output logic          touch_o,
    output logic          partial_o
);
    logic first_in;
    logic last_in;

    always_comb begin
        first_in  = valid_i && (first_i >= start_i) && (first_i <= end_i);
        last_in   = valid_i && (last_i  >= start_i) && (last_i  <= end_i);
        touch_o   = first_in | last_in;
        partial_o = first_in ^ last_in;
    end

endmodule

// File: rtl/pmp_hit_select.sv
`timescale 1ns/1ps
module pmp_hit_select #(
    parameter int NUM_ENTRIES = 8,
    parameter int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic [NUM_ENTRIES-1:0] touch_i,
    input  logic [NUM_ENTRIES-1:0] partial_i,
    output logic [NUM_ENTRIES-1:0] win_o,
    output logic                   any_o,
    output logic                   partial_o,
    output logic [IDX_W-1:0]       idx_o
);
    // Lowest set bit of the touch vector wins.
    always_comb begin
        win_o = touch_i & (~touch_i + NUM_ENTRIES'(1));
        any_o = |touch_i;
    end

    always_comb begin
        idx_o     = '0;
        partial_o = 1'b0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (win_o[i]) begin
                idx_o     = IDX_W'(i);
                partial_o = partial_i[i];
            end
        end
    end

endmodule

// File: rtl/pmp_access_checker.sv
`timescale 1ns/1ps
module pmp_access_checker
    import pmpchk_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int NUM_ENTRIES = 8,
    parameter int SIZE_W      = 8,
    parameter int PAGE_BYTES  = 4096,
    parameter bit OUT_REG     = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [XLEN+1:0]               acc_addr,
    input  logic [SIZE_W-1:0]             acc_size,
    input  logic [2:0]                    acc_perm,
    input  logic                          acc_machine,
    input  logic [NUM_ENTRIES*CFG_W-1:0]  cfg_flat,
    input  logic [NUM_ENTRIES*XLEN-1:0]   addr_flat,
    input  logic [NUM_ENTRIES-1:0]        lock_flat,
    output logic                          grant,
    output logic [2:0]                    allow_perm
);
    localparam int AW    = XLEN + 2;
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam logic [AW-1:0] PAGE_MASK = AW'(PAGE_BYTES - 1);

    // ---------------- access span ----------------
    logic [AW-1:0] last_byte;

    always_comb begin
        if (acc_size == '0)
            last_byte = acc_addr | PAGE_MASK;
        else
            last_byte = acc_addr + AW'(acc_size) - AW'(1);
    end

    // ---------------- per-entry decode and hit ----------------
    logic [AW-1:0]          rng_start [NUM_ENTRIES];
    logic [AW-1:0]          rng_end   [NUM_ENTRIES];
    amode_e                 ent_mode  [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] ent_valid;
    logic [NUM_ENTRIES-1:0] ent_touch;
    logic [NUM_ENTRIES-1:0] ent_partial;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
        logic [XLEN-1:0] prev_addr;

        if (g == 0) begin : g_first
            assign prev_addr = '0;
        end else begin : g_rest
            assign prev_addr = addr_flat[(g-1)*XLEN +: XLEN];
        end

        assign ent_mode[g] = cfg_mode(cfg_flat[g*CFG_W +: CFG_W]);

        pmp_range_decode #(
            .XLEN (XLEN)
        ) u_dec (
            .mode_i  (ent_mode[g]),
            .addr_i  (addr_flat[g*XLEN +: XLEN]),
            .prev_i  (prev_addr),
            .valid_o (ent_valid[g]),
            .start_o (rng_start[g]),
            .end_o   (rng_end[g])
        );

        pmp_entry_hit #(
            .AW (AW)
        ) u_hit (
            .valid_i   (ent_valid[g]),
            .start_i   (rng_start[g]),
            .end_i     (rng_end[g]),
            .first_i   (acc_addr),
            .last_i    (last_byte),
            .touch_o   (ent_touch[g]),
            .partial_o (ent_partial[g])
        );

        AST_NA4_SPAN: assert property (@(posedge clk) disable iff (rst)
            (ent_mode[g] == AM_NA4) |-> (rng_end[g] - rng_start[g] == AW'(3))); // R3
        AST_NAPOT_ALIGN: assert property (@(posedge clk) disable iff (rst)
            (ent_mode[g] == AM_NAPOT) |->
            ((rng_start[g] & (rng_end[g] - rng_start[g])) == '0)); // R4
        AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
            (ent_mode[g] == AM_OFF) |-> !ent_touch[g]); // R1
    end

    // ---------------- priority selection ----------------
    logic [NUM_ENTRIES-1:0] win_vec;
    logic                   any_touch;
    logic                   sel_partial;
    logic [IDX_W-1:0]       sel_idx;

    pmp_hit_select #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .IDX_W       (IDX_W)
    ) u_sel (
        .touch_i   (ent_touch),
        .partial_i (ent_partial),
        .win_o     (win_vec),
        .any_o     (any_touch),
        .partial_o (sel_partial),
        .idx_o     (sel_idx)
    );

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(win_vec) && (any_touch == (win_vec != '0))); // R6

    // ---------------- permission decision ----------------
    logic            rules_active;
    logic            sel_lock;
    perm_t           sel_perm;
    perm_t           allowed;
    perm_t           want;
    logic            grant_d;
    perm_t           perm_d;

    always_comb begin
        rules_active = |ent_valid;
        sel_lock     = lock_flat[sel_idx];
        sel_perm     = cfg_perm(cfg_flat[sel_idx*CFG_W +: CFG_W]);
        want         = perm_t'(acc_perm);
        allowed      = (acc_machine && !sel_lock) ? PERM_ALL : sel_perm;

        if (!rules_active || !any_touch) begin
            grant_d = acc_machine;
            perm_d  = acc_machine ? PERM_ALL : PERM_NONE;
        end else if (sel_partial) begin
            grant_d = 1'b0;
            perm_d  = PERM_NONE;
        end else begin
            grant_d = perm_covers(want, allowed);
            perm_d  = allowed;
        end
    end

    AST_PARTIAL_DENY: assert property (@(posedge clk) disable iff (rst)
        (any_touch && sel_partial) |-> (!grant_d && perm_d == PERM_NONE)); // R7
    AST_GRANT_SUBSET: assert property (@(posedge clk) disable iff (rst)
        grant_d |-> ((acc_perm & ~perm_d) == 3'b000)); // R8
    AST_MMODE_OPEN: assert property (@(posedge clk) disable iff (rst)
        (any_touch && !sel_partial && acc_machine && !sel_lock) |-> (perm_d == PERM_ALL)); // R8
    AST_NOMATCH_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        !any_touch |-> (grant_d == acc_machine && perm_d == (acc_machine ? PERM_ALL : PERM_NONE))); // R9

    // ---------------- output stage ----------------
    if (OUT_REG) begin : g_oreg
        always_ff @(posedge clk) begin
            if (rst) begin
                grant      <= 1'b0;
                allow_perm <= 3'b000;
            end else begin
                grant      <= grant_d;
                allow_perm <= perm_d;
            end
        end
        AST_RESET_CLEAR: assert property (@(posedge clk)
            $past(rst) |-> (!grant && allow_perm == 3'b000)); // R11
    end else begin : g_ocomb
        assign grant      = grant_d;
        assign allow_perm = perm_d;
    end

endmodule

// File: tb/pmp_access_checker_test.sv
`timescale 1ns/1ps
module pmp_access_checker_test;
    localparam int XLEN = 32;
    localparam int N    = 8;
    localparam int SW   = 8;
    localparam int AW   = XLEN + 2;
    localparam longint unsigned AMASK = (64'd1 << AW) - 64'd1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [AW-1:0]   acc_addr = '0;
    logic [SW-1:0]   acc_size = '0;
    logic [2:0]      acc_perm = '0;
    logic            acc_machine = 1'b0;
    logic [N*5-1:0]  cfg_flat = '0;
    logic [N*XLEN-1:0] addr_flat = '0;
    logic [N-1:0]    lock_flat = '0;
    logic            grant;
    logic [2:0]      allow_perm;

    logic [4:0]      cfg_a [N];
    logic [XLEN-1:0] adr_a [N];
    logic            lk_a  [N];

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    pmp_access_checker #(.XLEN(XLEN), .NUM_ENTRIES(N), .SIZE_W(SW)) uut (
        .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_size(acc_size),
        .acc_perm(acc_perm), .acc_machine(acc_machine), .cfg_flat(cfg_flat),
        .addr_flat(addr_flat), .lock_flat(lock_flat), .grant(grant),
        .allow_perm(allow_perm)
    );

    task automatic clear_entries();
        for (int i = 0; i < N; i++) begin
            cfg_a[i] = '0; adr_a[i] = '0; lk_a[i] = 1'b0;
        end
    endtask

    task automatic set_entry(int i, int mode, int perm, logic [XLEN-1:0] a, logic l);
        cfg_a[i] = {mode[1:0], perm[2:0]};
        adr_a[i] = a;
        lk_a[i]  = l;
    endtask

    task automatic check(string req, logic eg, logic [2:0] ep);
        checks++;
        if (grant !== eg || allow_perm !== ep) begin
            errors++;
            $display("FAIL %s: grant=%0b perm=%0h expected grant=%0b perm=%0h addr=%0h size=%0d",
                     req, grant, allow_perm, eg, ep, acc_addr, acc_size);
        end
    endtask

    // Drive on a falling edge, let one rising edge pass, sample on the next fall.
    task automatic access(longint unsigned a, int sz, int pm, logic m);
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            cfg_flat[i*5 +: 5]       = cfg_a[i];
            addr_flat[i*XLEN +: XLEN] = adr_a[i];
            lock_flat[i]             = lk_a[i];
        end
        acc_addr = AW'(a); acc_size = SW'(sz); acc_perm = pm[2:0]; acc_machine = m;
        @(negedge clk);
    endtask

    function automatic logic [3:0] model();
        longint unsigned a, last, sa, ea, ar, pr;
        logic s, e;
        logic [2:0] al;
        int t;
        a = longint'(acc_addr);
        if (acc_size == 0) last = a | 64'hFFF;
        else last = (a + longint'(acc_size) - 1) & AMASK;
        for (int i = 0; i < N; i++) begin
            ar = longint'(adr_a[i]);
            pr = (i == 0) ? 0 : longint'(adr_a[i-1]);
            sa = 0; ea = 0;
            case (cfg_a[i][4:3])
                2'd1: begin sa = pr << 2; ea = ((ar << 2) - 1) & AMASK; end
                2'd2: begin sa = ar << 2; ea = sa + 3; end
                2'd3: begin
                    if (adr_a[i] == '1) begin sa = 0; ea = AMASK; end
                    else begin
                        t = 0;
                        while (adr_a[i][t]) t++;
                        sa = (ar & ~((64'd1 << t) - 1)) << 2;
                        ea = sa + (64'd1 << (t + 3)) - 1;
                    end
                end
                default: ;
            endcase
            if (cfg_a[i][4:3] != 2'd0) begin
                s = (a >= sa) && (a <= ea);
                e = (last >= sa) && (last <= ea);
                if (s != e) return 4'b0000;
                if (s && e) begin
                    al = (acc_machine && !lk_a[i]) ? 3'b111 : cfg_a[i][2:0];
                    return {((acc_perm & ~al) == 3'b000), al};
                end
            end
        end
        return acc_machine ? 4'b1111 : 4'b0000;
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: expired, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [3:0] ex;
        void'($urandom(32'd7321));
        clear_entries();

        // R11: reset holds outputs low even when a machine access would pass
        acc_machine = 1'b1;
        repeat (4) @(negedge clk);
        check("R11 reset", 1'b0, 3'b000);
        @(negedge clk); rst = 1'b0;

        // R9: no active rules
        access(64'h100, 4, 1, 1'b0); check("R9 user no rules", 1'b0, 3'b000);
        access(64'h100, 4, 7, 1'b1); check("R9 machine no rules", 1'b1, 3'b111);

        // R11: registered latency, old result visible before the edge
        @(negedge clk); acc_machine = 1'b0;
        #1; check("R11 before edge", 1'b1, 3'b111);
        @(negedge clk); check("R11 after edge", 1'b0, 3'b000);

        // R1: off entry with full permissions is ignored
        set_entry(0, 0, 7, 32'h400, 1'b0);
        access(64'h10, 4, 1, 1'b0); check("R1 off entry", 1'b0, 3'b000);

        // R2: top-of-range regions 0..0xFF and 0x100..0x1FF
        set_entry(0, 1, 1, 32'h40, 1'b0);
        set_entry(1, 1, 3, 32'h80, 1'b0);
        access(64'hFC, 4, 1, 1'b0);  check("R2 tor top edge", 1'b1, 3'b001);
        access(64'h0, 4, 2, 1'b0);   check("R8 tor write denied", 1'b0, 3'b001);
        access(64'h100, 4, 2, 1'b0); check("R2 tor second base", 1'b1, 3'b011);
        access(64'h200, 4, 1, 1'b0); check("R2 tor past end", 1'b0, 3'b000);

        // R7: straddle between entry 0 and entry 1
        access(64'hFE, 4, 1, 1'b0);  check("R7 straddle", 1'b0, 3'b000);
        access(64'hFE, 4, 1, 1'b1);  check("R7 straddle machine", 1'b0, 3'b000);

        // R8: machine mode vs lock
        access(64'h10, 4, 4, 1'b1);  check("R8 machine unlocked", 1'b1, 3'b111);
        lk_a[0] = 1'b1;
        access(64'h10, 4, 4, 1'b1);  check("R8 machine locked", 1'b0, 3'b001);
        lk_a[0] = 1'b0;

        // R3: four-byte region 0x400..0x403
        set_entry(2, 2, 4, 32'h100, 1'b0);
        access(64'h400, 4, 4, 1'b0); check("R3 na4 fit", 1'b1, 3'b100);
        access(64'h402, 4, 4, 1'b0); check("R3 na4 overhang", 1'b0, 3'b000);
        access(64'h3FF, 1, 4, 1'b0); check("R3 na4 below", 1'b0, 3'b000);

        // R4: power-of-two region 0x800..0x83F (three trailing ones)
        set_entry(3, 3, 3, 32'h207, 1'b0);
        access(64'h83C, 4, 3, 1'b0); check("R4 napot top", 1'b1, 3'b011);
        access(64'h800, 1, 1, 1'b0); check("R4 napot base", 1'b1, 3'b011);
        access(64'h840, 4, 1, 1'b0); check("R4 napot past", 1'b0, 3'b000);

        // R6: higher entry overlapping entry 2 loses
        set_entry(4, 2, 1, 32'h100, 1'b0);
        access(64'h400, 4, 4, 1'b0); check("R6 priority", 1'b1, 3'b100);

        // R5: all-ones power-of-two covers everything else
        set_entry(5, 3, 1, 32'hFFFF_FFFF, 1'b0);
        access(64'h3000, 4, 1, 1'b0);        check("R5 full space read", 1'b1, 3'b001);
        access(64'h3_FFFF_FFFC, 4, 2, 1'b0); check("R5 full space write", 1'b0, 3'b001);

        // R10: size zero runs to page end
        clear_entries();
        set_entry(0, 1, 1, 32'h400, 1'b0);
        access(64'hF00, 0, 1, 1'b0); check("R10 size0 inside", 1'b1, 3'b001);
        set_entry(0, 1, 1, 32'h3C0, 1'b0);
        access(64'hE00, 0, 1, 1'b0); check("R10 size0 crosses", 1'b0, 3'b000);
        access(64'hEF8, 8, 1, 1'b0); check("R10 size8 fits", 1'b1, 3'b001);
        access(64'hEF8, 16, 1, 1'b0); check("R10 size16 crosses", 1'b0, 3'b000);

        // Random configurations and accesses against the model (R2 R3 R4 R6 R7 R8 R9 R10)
        for (int it = 0; it < 3000; it++) begin
            if (it % 16 == 0) begin
                for (int i = 0; i < N; i++) begin
                    int md, base, t;
                    logic [XLEN-1:0] av;
                    md = $urandom % 4;
                    base = $urandom % 1024;
                    if (md == 3) begin
                        t = $urandom % 6;
                        av = XLEN'(((base >> (t + 1)) << (t + 1)) | ((1 << t) - 1));
                        if ($urandom % 40 == 0) av = '1;
                    end else av = XLEN'(base);
                    set_entry(i, md, $urandom % 8, av, logic'($urandom % 2));
                end
            end
            access(longint'($urandom % 4300), $urandom % 10, $urandom % 8, logic'($urandom % 2));
            ex = model();
            check("R8 random", ex[3], ex[2:0]);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule